// File: doc/BRIEF.md
# Service-Level / Virtual-Channel Router Input Port

This block is the receive side of one port of a packet router that carries several priority classes (service levels), each split into one or more equal-priority virtual channels. Flits arrive on a single valid/ready link. Every flit carries a two-bit kind field, a service-level tag and a virtual-channel tag. The port sends each flit to exactly one per-channel buffer in a grid of service level by virtual channel. Only that buffer takes part in the link handshake. The tags are consumed at this point, so what goes onward into the switch is the flit kind and the data word alone.

Each channel buffer decodes the flit at its head. A header flit names its output port in the two least significant data bits. It raises a request to that one port, and its data word is rotated right by two bits so that the next router finds its own index in the low bits. Body and tail flits raise a single shared request that every output port sees. When the downstream switch acknowledges a channel's head flit, the buffer frees a slot and returns a one-cycle credit pulse toward the upstream sender on that channel. Each service level can have its own number of virtual channels. A flit tagged for a channel that does not exist is consumed and discarded, and a sticky error flag is raised.

Top module: `mip_in_port`

## Requirements
- R1: A flit accepted at a clock edge with service level s and virtual channel v is presented on channel c = s*MAX_VC + v from the next cycle on (ch_valid_o[c] high), and no other channel output changes.
- R2: in_ready_o follows only the buffer selected by the current tags. A full buffer on one channel does not block a flit addressed to a different channel.
- R3: A header flit (kind 2'b01) at a channel head drives exactly one bit of that channel's 4-bit hdr_req_o group: bit data[1:0]. bt_req_o for that channel stays low.
- R4: The data word of a header flit is presented rotated right by two bits (data[1:0] move to the top two positions).
- R5: A body (2'b10) or tail (2'b11) flit at a channel head raises bt_req_o for that channel with all of its hdr_req_o bits low and its data unchanged. ch_last_o is high only for a tail.
- R6: credit_o[c] is high in exactly the cycles in which ch_ack_i[c] is high while channel c holds a flit. That flit leaves at the following edge.
- R7: The number of virtual channels is set per service level (default 2, 2, 1, 1 for levels 0 to 3). A flit whose virtual-channel tag is not below its level's count is accepted (in_ready_o high), stored nowhere, and sets err_o from the next cycle until reset.
- R8: A channel buffer holds DEPTH flits (default 1). When it is full, in_ready_o is low for that channel unless the channel's head flit is acknowledged in the same cycle. In that case a new flit is accepted at the same edge the old one leaves.
- R9: After reset every channel is empty, every request and credit output is low, err_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Link flit valid |
| in_ready_o | output | 1 | Link flit accepted when high together with valid |
| in_kind_i | input | 2 | Flit kind: 01 header, 10 body, 11 tail |
| in_sl_i | input | SLW | Service-level tag |
| in_vc_i | input | VCW | Virtual-channel tag |
| in_data_i | input | DW | Flit data word |
| ch_valid_o | output | NCH | Per-channel head flit present |
| ch_ack_i | input | NCH | Per-channel head flit taken by the switch |
| ch_data_o | output | NCH*DW | Per-channel outgoing data, tags removed |
| ch_last_o | output | NCH | Per-channel head is a tail flit |
| hdr_req_o | output | NCH*4 | Per-channel one-hot output-port request for headers |
| bt_req_o | output | NCH | Per-channel shared request for body and tail flits |
| credit_o | output | NCH | Per-channel credit pulse back to the upstream link |
| err_o | output | 1 | Sticky flag for flits addressed to a missing channel |

## Verification
The two functions that can coincide are the departure of a full buffer's head flit and the arrival of a new flit for the same channel. The credit pulse and the link acceptance then fall in one cycle. The bench fills a one-deep channel, holds it, and checks that a second flit for that channel is refused while a flit for a neighbouring channel would be accepted. It then raises the acknowledge together with the waiting flit and expects ready and credit high in the same cycle. In the next cycle the channel must present the new data word rather than the old one or nothing.

// File: rtl/mip_pkg.sv
package mip_pkg;
  typedef enum logic [1:0] {
    FK_IDLE = 2'b00,
    FK_HEAD = 2'b01,
    FK_BODY = 2'b10,
    FK_TAIL = 2'b11
  } flit_kind_e;

  localparam int unsigned PIDX_W = 2;
  localparam int unsigned NPORT  = 1 << PIDX_W;
endpackage

// File: rtl/mip_chan_buf.sv
module mip_chan_buf #(
  parameter int unsigned DEPTH = 1,
  parameter int unsigned W     = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         ready_o,
  output logic         valid_o,
  output logic [W-1:0] dout_o,
  input  logic         ack_i,
  output logic         credit_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign valid_o  = (cnt_q != '0);
  assign pop      = ack_i & valid_o;
  assign ready_o  = (cnt_q != CW'(DEPTH)) | pop;
  assign dout_o   = mem_q[rd_q];
  assign credit_o = pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop)    rd_q <= nxt(rd_q);
      if (push_i && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  // R8
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(DEPTH) && !ack_i) |-> !ready_o);
  // R6
  credit_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_o && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R1
  push_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !credit_o) |=> valid_o);
endmodule

// File: rtl/mip_flit_dec.sv
module mip_flit_dec
  import mip_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             valid_i,
  input  flit_kind_e       kind_i,
  input  logic [DW-1:0]    data_i,
  output logic [NPORT-1:0] hdr_req_o,
  output logic             bt_req_o,
  output logic             last_o,
  output logic [DW-1:0]    data_o
);
  logic is_hdr;

  assign is_hdr = (kind_i == FK_HEAD);

  always_comb begin
    hdr_req_o = '0;
    if (valid_i && is_hdr) hdr_req_o[data_i[PIDX_W-1:0]] = 1'b1;
  end

  assign bt_req_o = valid_i & !is_hdr;
  assign last_o   = valid_i & (kind_i == FK_TAIL);
  // rotate so the next hop's index lands in the low bits
  assign data_o   = is_hdr ? {data_i[PIDX_W-1:0], data_i[DW-1:PIDX_W]} : data_i;
endmodule

// File: rtl/mip_in_port.sv
module mip_in_port
  import mip_pkg::*;
#(
  parameter int unsigned                     NUM_SL = 4,
  parameter int unsigned                     MAX_VC = 2,
  parameter logic [NUM_SL-1:0][3:0]          VC_CNT = {4'd1, 4'd1, 4'd2, 4'd2},
  parameter int unsigned                     DW     = 16,
  parameter int unsigned                     DEPTH  = 1,
  localparam int unsigned                    SLW    = (NUM_SL > 1) ? $clog2(NUM_SL) : 1,
  localparam int unsigned                    VCW    = (MAX_VC > 1) ? $clog2(MAX_VC) : 1,
  localparam int unsigned                    NCH    = NUM_SL * MAX_VC
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [1:0]            in_kind_i,
  input  logic [SLW-1:0]        in_sl_i,
  input  logic [VCW-1:0]        in_vc_i,
  input  logic [DW-1:0]         in_data_i,
  output logic [NCH-1:0]        ch_valid_o,
  input  logic [NCH-1:0]        ch_ack_i,
  output logic [NCH*DW-1:0]     ch_data_o,
  output logic [NCH-1:0]        ch_last_o,
  output logic [NCH*NPORT-1:0]  hdr_req_o,
  output logic [NCH-1:0]        bt_req_o,
  output logic [NCH-1:0]        credit_o,
  output logic                  err_o
);
  localparam int unsigned CIW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned BW  = DW + 2;

  logic           tag_ok;
  logic [CIW-1:0] ch_idx;
  logic [NCH-1:0] buf_ready, push_vec;
  logic           err_q;

  always_comb begin
    tag_ok = 1'b0;
    if (int'(in_sl_i) < NUM_SL)
      tag_ok = int'(in_vc_i) < int'(VC_CNT[in_sl_i]);
  end

  assign ch_idx     = CIW'(int'(in_sl_i) * MAX_VC + int'(in_vc_i));
  assign in_ready_o = tag_ok ? buf_ready[ch_idx] : 1'b1;

  always_comb begin
    push_vec = '0;
    if (in_valid_i && tag_ok && buf_ready[ch_idx]) push_vec[ch_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     err_q <= 1'b0;
    else if (in_valid_i && !tag_ok)  err_q <= 1'b1;
  end
  assign err_o = err_q;

  for (genvar s = 0; s < NUM_SL; s++) begin : g_sl
    for (genvar v = 0; v < MAX_VC; v++) begin : g_vc
      localparam int unsigned C = s * MAX_VC + v;
      if (v < int'(VC_CNT[s])) begin : g_live
        logic [BW-1:0] head;
        logic          hv;

        mip_chan_buf #(.DEPTH(DEPTH), .W(BW)) u_buf (
          .clk_i    (clk_i),
          .rst_ni   (rst_ni),
          .push_i   (push_vec[C]),
          .din_i    ({in_kind_i, in_data_i}),
          .ready_o  (buf_ready[C]),
          .valid_o  (hv),
          .dout_o   (head),
          .ack_i    (ch_ack_i[C]),
          .credit_o (credit_o[C])
        );

        mip_flit_dec #(.DW(DW)) u_dec (
          .valid_i   (hv),
          .kind_i    (flit_kind_e'(head[BW-1 -: 2])),
          .data_i    (head[DW-1:0]),
          .hdr_req_o (hdr_req_o[C*NPORT +: NPORT]),
          .bt_req_o  (bt_req_o[C]),
          .last_o    (ch_last_o[C]),
          .data_o    (ch_data_o[C*DW +: DW])
        );
        assign ch_valid_o[C] = hv;

        // R3
        hdr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          $onehot0(hdr_req_o[C*NPORT +: NPORT]));
        // R3
        hdr_bt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !(|hdr_req_o[C*NPORT +: NPORT] && bt_req_o[C]));
        // R6
        credit_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          credit_o[C] |-> (ch_valid_o[C] && ch_ack_i[C]));
      end else begin : g_dead
        assign buf_ready[C]                = 1'b0;
        assign ch_valid_o[C]               = 1'b0;
        assign ch_data_o[C*DW +: DW]       = '0;
        assign ch_last_o[C]                = 1'b0;
        assign hdr_req_o[C*NPORT +: NPORT] = '0;
        assign bt_req_o[C]                 = 1'b0;
        assign credit_o[C]                 = 1'b0;
      end
    end
  end

  // R2
  one_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_vec));
  // R7
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && push_vec == '0) |=> err_o);
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: tb/mip_in_port_tb.sv
module mip_in_port_tb_top;
  localparam int DW = 16, NCH = 8, NP = 4;
  localparam logic [1:0] K_HDR = 2'b01, K_BODY = 2'b10, K_TAIL = 2'b11;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              in_valid = 1'b0, in_ready;
  logic [1:0]        in_kind = '0;
  logic [1:0]        in_sl = '0;
  logic [0:0]        in_vc = '0;
  logic [DW-1:0]     in_data = '0;
  logic [NCH-1:0]    ch_valid, ch_ack = '0, ch_last, bt_req, credit;
  logic [NCH*DW-1:0] ch_data;
  logic [NCH*NP-1:0] hdr_req;
  logic              err;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mip_in_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_kind_i(in_kind), .in_sl_i(in_sl), .in_vc_i(in_vc), .in_data_i(in_data),
    .ch_valid_o(ch_valid), .ch_ack_i(ch_ack), .ch_data_o(ch_data),
    .ch_last_o(ch_last), .hdr_req_o(hdr_req), .bt_req_o(bt_req),
    .credit_o(credit), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic present(input logic [1:0] k, input logic [1:0] s, input logic v,
                         input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_sl = s; in_vc = v; in_data = d;
    #1;
  endtask

  task automatic accept_edge();
    @(posedge clk); #1;
    in_valid = 1'b0;
    ch_ack   = '0;
  endtask

  task automatic drain(input int c);
    @(negedge clk);
    ch_ack[c] = 1'b1;
    #1 chk("R6 credit on drain", 32'(credit), 32'(1) << c);
    accept_edge();
    @(negedge clk);
    chk("R6 channel empty after drain", 32'(ch_valid), 32'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 ready after reset", 32'(in_ready), 32'h1);
    chk("R9 no channel valid", 32'(ch_valid), 32'h0);
    chk("R9 no header request", hdr_req, 32'h0);
    chk("R9 no shared request", 32'(bt_req), 32'h0);
    chk("R9 no credit", 32'(credit), 32'h0);
    chk("R9 err clear", 32'(err), 32'h0);
  endtask

  task automatic t_header();
    logic [DW-1:0] d = 16'hABCE;
    present(K_HDR, 2'd1, 1'b1, d);
    chk("R2 ready for empty channel", 32'(in_ready), 32'h1);
    accept_edge();
    @(negedge clk);
    chk("R1 header lands on channel 3", 32'(ch_valid), 32'h08);
    chk("R3 port 2 request only", hdr_req, 32'(1) << (3*NP + 2));
    chk("R3 shared request low on header", 32'(bt_req), 32'h0);
    chk("R4 rotated header data", 32'(ch_data[3*DW +: DW]), 32'({d[1:0], d[DW-1:2]}));
    drain(3);
  endtask

  task automatic t_body_tail();
    present(K_BODY, 2'd0, 1'b0, 16'h1234);
    accept_edge();
    @(negedge clk);
    chk("R1 body lands on channel 0", 32'(ch_valid), 32'h01);
    chk("R5 shared request on body", 32'(bt_req), 32'h01);
    chk("R5 no header request on body", hdr_req, 32'h0);
    chk("R5 body data unchanged", 32'(ch_data[0 +: DW]), 32'h1234);
    chk("R5 body not last", 32'(ch_last), 32'h0);
    drain(0);
    present(K_TAIL, 2'd3, 1'b0, 16'h0007);
    accept_edge();
    @(negedge clk);
    chk("R7 one-channel level 3 exists at channel 6", 32'(ch_valid), 32'h40);
    chk("R5 tail marked last", 32'(ch_last), 32'h40);
    chk("R5 tail data unchanged", 32'(ch_data[6*DW +: DW]), 32'h0007);
    drain(6);
  endtask

  task automatic t_full_overlap();
    present(K_BODY, 2'd0, 1'b0, 16'h1111);
    accept_edge();
    present(K_BODY, 2'd0, 1'b0, 16'h2222);
    chk("R8 full channel refuses", 32'(in_ready), 32'h0);
    in_vc = 1'b1; #1;
    chk("R2 other channel still ready", 32'(in_ready), 32'h1);
    in_vc = 1'b0; ch_ack[0] = 1'b1; #1;
    chk("R8 ready when head leaves same cycle", 32'(in_ready), 32'h1);
    chk("R6 credit with overlap", 32'(credit), 32'h01);
    accept_edge();
    @(negedge clk);
    chk("R8 channel 0 holds new flit", 32'(ch_valid), 32'h01);
    chk("R8 new data after overlap", 32'(ch_data[0 +: DW]), 32'h2222);
    drain(0);
  endtask

  task automatic t_missing_vc();
    present(K_BODY, 2'd2, 1'b1, 16'hBEEF);
    chk("R7 missing channel still accepted", 32'(in_ready), 32'h1);
    chk("R7 err not yet set", 32'(err), 32'h0);
    accept_edge();
    @(negedge clk);
    chk("R7 err set after drop", 32'(err), 32'h1);
    chk("R7 dropped flit stored nowhere", 32'(ch_valid), 32'h0);
    present(K_HDR, 2'd1, 1'b0, 16'h0001);
    accept_edge();
    @(negedge clk);
    chk("R7 err stays set", 32'(err), 32'h1);
    chk("R1 header lands on channel 2", 32'(ch_valid), 32'h04);
    chk("R3 port 1 request", hdr_req, 32'(1) << (2*NP + 1));
    drain(2);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_header();
    t_body_tail();
    t_full_overlap();
    t_missing_vc();
    repeat (2) @(negedge clk);
    report();
  end
endmodule